// File: doc/BRIEF.md
# Streaming Image Downscaler

This block shrinks a raster-ordered grayscale pixel stream. The horizontal and vertical ratios are independent of each other. The pixel stream enters with a valid flag and four framing markers: line start, line end, frame start and frame end. The downscaled stream leaves with the same five control signals, regenerated so that they frame exactly the requested output size.

The input and output frame sizes and the blend mode arrive on ports. They are captured together with the first pixel of each frame, and that first pixel already uses them. Two phase accumulators decide which input columns and rows yield output samples. Each accumulator adds the output size for every input step and emits a sample whenever the sum reaches the input size. The remainder after that subtraction becomes a fixed-point blend weight.

The blend runs vertically first, between the current pixel and the pixel one line above, which is held in a single line store. It then runs horizontally, between that result and the previous column's result. The blend is either a weighted two-tap sum or a pick of the nearer tap.

Top module: `img_downscaler`

## Requirements
- R1: Sizes (`in_w`, `in_h`, `out_w`, `out_h`) and `mix_sel` are taken only in a cycle with `in_valid` and `in_vstart` both high; later changes on those ports during the frame have no effect on its output.
- R2: Each emitting input line yields exactly `out_w` output pixels; `out_hstart` marks the first of them and `out_hend` the last.
- R3: `out_vstart` marks the first output pixel of a frame and `out_vend` the last one, the `out_w`-th pixel of output row `out_h`.
- R4: Per input line, a column accumulator starts at 0 and adds `out_w` for each valid pixel; when the sum is at least `in_w`, that column emits and the accumulator keeps the remainder `sum - in_w`, otherwise it keeps the sum.
- R5: Per frame, a row accumulator starts at 0 and adds `out_h` at each line start; the line emits when the sum is at least `in_h`, and the kept value follows the same rule as R4.
- R6: With `mix_sel`=1 (linear), weight w = floor(rem·256/size) for 8 weight bits. Each tap pair blends as floor((cur·(256−w) + prev·w)/256): first current pixel with the pixel above, then that result with the previous column's result.
- R7: With `mix_sel`=0 (nearest), each direction yields the previous tap when w ≥ 128, and the current tap otherwise.
- R8: On the first row and first column, the missing neighbour is replaced by the sample itself; equal input and output sizes pass every pixel through unchanged.
- R9: An output appears in the cycle after the input pixel that produced it. When `out_valid` is low, all outputs are 0, including directly after reset.
- R10: Cycles with `in_valid` low change nothing, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_pix | input | PIX_W | Input pixel |
| in_valid | input | 1 | Input pixel valid |
| in_hstart | input | 1 | First pixel of an input line |
| in_hend | input | 1 | Last pixel of an input line |
| in_vstart | input | 1 | First pixel of an input frame |
| in_vend | input | 1 | Last pixel of an input frame |
| in_w | input | AW | Input pixels per line |
| in_h | input | AW | Input lines per frame |
| out_w | input | AW | Output pixels per line |
| out_h | input | AW | Output lines per frame |
| mix_sel | input | 1 | 1 = linear blend, 0 = nearest pick |
| out_pix | output | PIX_W | Output pixel |
| out_valid | output | 1 | Output pixel valid |
| out_hstart | output | 1 | First pixel of an output line |
| out_hend | output | 1 | Last pixel of an output line |
| out_vstart | output | 1 | First pixel of an output frame |
| out_vend | output | 1 | Last pixel of an output frame |

## Verification
A wrong column accumulator value shows in the next cycle as an output pixel in a wrong column or a missing one. That also moves `out_hend` away from the `out_w`-th pixel within the same line. A wrong row accumulator or row flag shifts or drops whole output lines, and `out_vend` then no longer lands on the final pixel. A stale line-store word or a wrong weight shows only in the pixel value, one cycle after the input pixel, so the bench compares every output field on every clock against an integer model.

// File: rtl/rsz_pkg.sv
package rsz_pkg;
  typedef enum logic {
    MIX_PICK   = 1'b0,
    MIX_LINEAR = 1'b1
  } mix_e;

  typedef struct packed {
    logic valid;
    logic hs;
    logic he;
    logic vs;
    logic ve;
  } ctl_t;
endpackage

// File: rtl/rsz_phase.sv
module rsz_phase #(
  parameter int AW = 7,
  parameter int WB = 8
) (
  input  logic          restart,
  input  logic [AW-1:0] acc,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] limit,
  output logic          emit,
  output logic [AW-1:0] next,
  output logic [WB-1:0] weight
);
  // floor(r * 2^WB / d) for r < d, by restoring division
  function automatic logic [WB-1:0] frac_of(input logic [AW-1:0] r,
                                            input logic [AW-1:0] d);
    logic [AW:0]   rem;
    logic [WB-1:0] q;
    rem = {1'b0, r};
    q   = '0;
    for (int i = WB - 1; i >= 0; i--) begin
      rem = rem << 1;
      if (rem >= {1'b0, d}) begin
        q[i] = 1'b1;
        rem  = rem - {1'b0, d};
      end
    end
    return q;
  endfunction

  logic [AW:0] sum;
  logic [AW:0] rem_full;

  always_comb begin
    sum      = (restart ? '0 : {1'b0, acc}) + {1'b0, step};
    emit     = sum >= {1'b0, limit};
    rem_full = sum - {1'b0, limit};
    next     = emit ? rem_full[AW-1:0] : sum[AW-1:0];
    weight   = emit ? frac_of(rem_full[AW-1:0], step) : '0;
  end
endmodule

// File: rtl/rsz_linestore.sv
module rsz_linestore #(
  parameter int DEPTH = 64,
  parameter int PW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [PW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [PW-1:0] rdata
);
  logic [PW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/img_downscaler.sv
module img_downscaler #(
  parameter int PIX_W = 8,
  parameter int WB    = 8,
  parameter int MAX_W = 64,
  parameter int MAX_H = 64,
  localparam int MAXD = (MAX_W > MAX_H) ? MAX_W : MAX_H,
  localparam int AW   = $clog2(MAXD + 1),
  localparam int XW   = $clog2(MAX_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             in_valid,
  input  logic             in_hstart,
  input  logic             in_hend,
  input  logic             in_vstart,
  input  logic             in_vend,
  input  logic [AW-1:0]    in_w,
  input  logic [AW-1:0]    in_h,
  input  logic [AW-1:0]    out_w,
  input  logic [AW-1:0]    out_h,
  input  logic             mix_sel,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_valid,
  output logic             out_hstart,
  output logic             out_hend,
  output logic             out_vstart,
  output logic             out_vend
);
  import rsz_pkg::*;

  localparam int PRW = PIX_W + WB + 1;

  function automatic logic [PIX_W-1:0] mix(input logic [PIX_W-1:0] cur,
                                           input logic [PIX_W-1:0] prev,
                                           input logic [WB-1:0] w,
                                           input mix_e md);
    logic [WB:0]    wc;
    logic [PRW-1:0] acc;
    if (md == MIX_PICK) return w[WB-1] ? prev : cur;
    wc  = (WB+1)'(1 << WB) - {1'b0, w};
    acc = PRW'(cur) * PRW'(wc) + PRW'(prev) * PRW'(w);
    return acc[PIX_W+WB-1:WB];
  endfunction

  // frame-size capture
  logic          cap;
  logic [AW-1:0] iw_q, ih_q, ow_q, oh_q;
  logic [AW-1:0] iw_e, ih_e, ow_e, oh_e;
  mix_e          md_q, md_e;
  logic          frame_seen;

  assign cap  = in_valid && in_vstart;
  assign iw_e = cap ? in_w : iw_q;
  assign ih_e = cap ? in_h : ih_q;
  assign ow_e = cap ? out_w : ow_q;
  assign oh_e = cap ? out_h : oh_q;
  assign md_e = cap ? mix_e'(mix_sel) : md_q;

  // row state, decided at each line start
  logic          v_emit_c;
  logic [AW-1:0] v_next_c, vacc_q;
  logic [WB-1:0] v_wt_c;
  logic          row_emit_q, row_first_q;
  logic [AW-1:0] row_next_q;
  logic [WB-1:0] row_wt_q;
  logic          row_emit_e, row_first_e;
  logic [AW-1:0] row_next_e;
  logic [WB-1:0] row_wt_e;

  rsz_phase #(.AW(AW), .WB(WB)) u_vph (
    .restart(in_vstart), .acc(vacc_q), .step(oh_e), .limit(ih_e),
    .emit(v_emit_c), .next(v_next_c), .weight(v_wt_c)
  );

  assign row_emit_e  = in_hstart ? v_emit_c  : row_emit_q;
  assign row_next_e  = in_hstart ? v_next_c  : row_next_q;
  assign row_wt_e    = in_hstart ? v_wt_c    : row_wt_q;
  assign row_first_e = in_hstart ? in_vstart : row_first_q;

  // column state
  logic [XW-1:0]    xcol_q, xcol_e;
  logic [PIX_W-1:0] lb_rd, prev_row, vval, pv_q, prev_col, hval;
  logic             h_emit;
  logic [AW-1:0]    h_next, hacc_q;
  logic [WB-1:0]    h_wt;

  assign xcol_e = in_hstart ? '0 : xcol_q;

  rsz_linestore #(.DEPTH(MAX_W), .PW(PIX_W)) u_lines (
    .clk(clk), .we(in_valid), .waddr(xcol_e), .wdata(in_pix),
    .raddr(xcol_e), .rdata(lb_rd)
  );

  assign prev_row = row_first_e ? in_pix : lb_rd;
  assign vval     = mix(in_pix, prev_row, row_wt_e, md_e);

  rsz_phase #(.AW(AW), .WB(WB)) u_hph (
    .restart(in_hstart), .acc(hacc_q), .step(ow_e), .limit(iw_e),
    .emit(h_emit), .next(h_next), .weight(h_wt)
  );

  assign prev_col = in_hstart ? vval : pv_q;
  assign hval     = mix(vval, prev_col, h_wt, md_e);

  // output grid position
  logic          take, last_col, last_row;
  logic [AW-1:0] ocol_q, orow_q, ocol_e, orow_e;

  assign take     = in_valid && h_emit && row_emit_e;
  assign ocol_e   = in_hstart ? '0 : ocol_q;
  assign orow_e   = in_vstart ? '0 : orow_q;
  assign last_col = ocol_e == ow_e - 1'b1;
  assign last_row = orow_e == oh_e - 1'b1;

  ctl_t ctl_d;
  always_comb begin
    ctl_d.valid = take;
    ctl_d.hs    = take && (ocol_e == '0);
    ctl_d.he    = take && last_col;
    ctl_d.vs    = take && (ocol_e == '0) && (orow_e == '0);
    ctl_d.ve    = take && last_col && last_row;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iw_q <= '0; ih_q <= '0; ow_q <= '0; oh_q <= '0;
      md_q <= MIX_PICK; frame_seen <= 1'b0;
      vacc_q <= '0; row_emit_q <= 1'b0; row_first_q <= 1'b0;
      row_next_q <= '0; row_wt_q <= '0;
      xcol_q <= '0; hacc_q <= '0; pv_q <= '0;
      ocol_q <= '0; orow_q <= '0;
      out_pix <= '0; out_valid <= 1'b0; out_hstart <= 1'b0;
      out_hend <= 1'b0; out_vstart <= 1'b0; out_vend <= 1'b0;
    end else begin
      if (cap) begin
        iw_q <= in_w; ih_q <= in_h; ow_q <= out_w; oh_q <= out_h;
        md_q <= mix_e'(mix_sel); frame_seen <= 1'b1;
      end
      if (in_valid) begin
        if (in_hstart) begin
          row_emit_q  <= v_emit_c;
          row_next_q  <= v_next_c;
          row_wt_q    <= v_wt_c;
          row_first_q <= in_vstart;
        end
        if (in_hend) vacc_q <= in_vend ? '0 : row_next_e;
        xcol_q <= xcol_e + 1'b1;
        hacc_q <= h_next;
        pv_q   <= vval;
        ocol_q <= take ? ocol_e + 1'b1 : ocol_e;
        orow_q <= (take && last_col) ? orow_e + 1'b1 : orow_e;
      end
      out_valid  <= ctl_d.valid;
      out_hstart <= ctl_d.hs;
      out_hend   <= ctl_d.he;
      out_vstart <= ctl_d.vs;
      out_vend   <= ctl_d.ve;
      out_pix    <= take ? hval : '0;
    end
  end

  // R1
  size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_vstart) |=> $stable(iw_q) && $stable(ow_q) && $stable(ih_q) && $stable(oh_q));
  // R4
  hacc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_seen |-> hacc_q < iw_q);
  // R2
  ocol_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ocol_e < ow_e);
  // R2
  line_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_hstart && out_hend));
  // R3
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vend |-> out_hend && out_valid);
  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_pix == '0) && !out_hstart && !out_hend && !out_vstart && !out_vend);
endmodule

// File: tb/sim_img_downscaler.sv
module sim_img_downscaler;
  localparam int PW = 8;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PW-1:0] in_pix = '0;
  logic in_valid = 0, in_hstart = 0, in_hend = 0, in_vstart = 0, in_vend = 0;
  logic [AW-1:0] in_w = '0, in_h = '0, out_w = '0, out_h = '0;
  logic mix_sel = 1'b0;
  logic [PW-1:0] out_pix;
  logic out_valid, out_hstart, out_hend, out_vstart, out_vend;

  always #10 clk = ~clk;

  img_downscaler u0 (
    .clk(clk), .rst_n(rst_n), .in_pix(in_pix), .in_valid(in_valid),
    .in_hstart(in_hstart), .in_hend(in_hend), .in_vstart(in_vstart), .in_vend(in_vend),
    .in_w(in_w), .in_h(in_h), .out_w(out_w), .out_h(out_h), .mix_sel(mix_sel),
    .out_pix(out_pix), .out_valid(out_valid), .out_hstart(out_hstart),
    .out_hend(out_hend), .out_vstart(out_vstart), .out_vend(out_vend)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  string tag = "R9";

  // reference state
  int m_iw, m_ih, m_ow, m_oh, m_lin;
  int m_hacc, m_vacc, m_remit, m_rw, m_rnext, m_first, m_x, m_pv, m_ocol, m_orow;
  int line_mem [256];
  int e_v, e_p, e_hs, e_he, e_vs, e_ve;

  function automatic int blend(int cur, int prev, int w, int lin);
    if (lin == 0) return (w >= 128) ? prev : cur;
    return (cur * (256 - w) + prev * w) / 256;
  endfunction

  task automatic model(int v, int pix, int hs, int he, int vs, int ve);
    int prow, vv, hb, s, hem, hw, pc, ov, oc, orr, tk;
    e_v = 0; e_p = 0; e_hs = 0; e_he = 0; e_vs = 0; e_ve = 0;
    if (v == 0) return;  // R10: nothing moves
    if (vs != 0) begin
      m_iw = in_w; m_ih = in_h; m_ow = out_w; m_oh = out_h; m_lin = mix_sel;
    end
    if (hs != 0) begin
      s = ((vs != 0) ? 0 : m_vacc) + m_oh;
      m_remit = (s >= m_ih);
      m_rw    = m_remit ? ((s - m_ih) * 256) / m_oh : 0;
      m_rnext = m_remit ? s - m_ih : s;
      m_first = vs;
      m_x     = 0;
    end
    prow = (m_first != 0) ? pix : line_mem[m_x];
    vv   = blend(pix, prow, m_rw, m_lin);
    hb   = (hs != 0) ? 0 : m_hacc;
    s    = hb + m_ow;
    hem  = (s >= m_iw);
    hw   = hem ? ((s - m_iw) * 256) / m_ow : 0;
    m_hacc = hem ? s - m_iw : s;
    pc   = (hs != 0) ? vv : m_pv;
    m_pv = vv;
    ov   = blend(vv, pc, hw, m_lin);
    line_mem[m_x] = pix;
    m_x++;
    if (he != 0) m_vacc = (ve != 0) ? 0 : m_rnext;
    tk  = hem && m_remit;
    oc  = (hs != 0) ? 0 : m_ocol;
    orr = (vs != 0) ? 0 : m_orow;
    e_v  = tk;
    e_p  = tk ? ov : 0;
    e_hs = tk && oc == 0;
    e_he = tk && oc == m_ow - 1;
    e_vs = tk && oc == 0 && orr == 0;
    e_ve = tk && oc == m_ow - 1 && orr == m_oh - 1;
    m_ocol = tk ? oc + 1 : oc;
    m_orow = (tk && oc == m_ow - 1) ? orr + 1 : orr;
  endtask

  task automatic compare();
    string f;
    total++;
    if (out_valid !== 1'(e_v) || out_pix !== PW'(e_p) || out_hstart !== 1'(e_hs) ||
        out_hend !== 1'(e_he) || out_vstart !== 1'(e_vs) || out_vend !== 1'(e_ve)) begin
      bad++;
      if (out_valid !== 1'(e_v)) f = "R4";
      else if (out_pix !== PW'(e_p)) f = (m_lin != 0) ? "R6" : "R7";
      else if (out_hstart !== 1'(e_hs) || out_hend !== 1'(e_he)) f = "R2";
      else f = "R3";
      $display("FAIL %s/%s t=%0t actual v=%0d pix=%0d hs=%0d he=%0d vs=%0d ve=%0d expected v=%0d pix=%0d hs=%0d he=%0d vs=%0d ve=%0d",
               tag, f, $time, out_valid, out_pix, out_hstart, out_hend, out_vstart, out_vend,
               e_v, e_p, e_hs, e_he, e_vs, e_ve);
    end
  endtask

  // one input cycle: drive at negedge, model, compare at next negedge (R9 latency)
  task automatic cyc(int v, int pix, int hs, int he, int vs, int ve);
    in_valid = 1'(v); in_pix = PW'(pix);
    in_hstart = 1'(hs); in_hend = 1'(he); in_vstart = 1'(vs); in_vend = 1'(ve);
    model(v, pix, hs, he, vs, ve);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n, int junk);
    for (int i = 0; i < n; i++) begin
      if (junk != 0) begin
        in_valid = 0; in_pix = PW'($urandom);
        in_hstart = 1'($urandom); in_hend = 1'($urandom);
        in_vstart = 1'b1; in_vend = 1'($urandom);
        model(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare();
      end else cyc(0, 0, 0, 0, 0, 0);
    end
  endtask

  task automatic frame(int iw, int ih, int ow, int oh, int lin, int seed,
                       int scramble, int gaps);
    in_w = AW'(iw); in_h = AW'(ih); out_w = AW'(ow); out_h = AW'(oh); mix_sel = 1'(lin);
    for (int y = 0; y < ih; y++) begin
      for (int x = 0; x < iw; x++) begin
        int p;
        p = (seed == 0) ? ((x * 37 + y * 11) & 255) : int'($urandom & 255);
        cyc(1, p, x == 0, x == iw - 1, x == 0 && y == 0, x == iw - 1 && y == ih - 1);
        if (scramble != 0 && x == 0 && y == 0) begin
          // R1: ports change after capture
          in_w = AW'(iw - 3); in_h = AW'(ih - 5); out_w = AW'(ow + 2); out_h = AW'(oh - 1);
          mix_sel = ~mix_sel;
        end
        if (gaps != 0 && ($urandom % 4) == 0) idle(1 + $urandom % 2, 1);
      end
      idle(2, gaps);
    end
    idle(3, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    total++;
    if (out_valid !== 0 || out_pix !== 0 || out_hstart !== 0 || out_hend !== 0 ||
        out_vstart !== 0 || out_vend !== 0) begin
      bad++;
      $display("FAIL R9 reset actual v=%0d pix=%0d expected v=0 pix=0", out_valid, out_pix);
    end
    rst_n = 1'b1;
    @(negedge clk);
    idle(2, 0);
    tag = "R6";  frame(32, 20, 16, 16, 1, 0, 0, 0);
    tag = "R7";  frame(40, 24, 17, 16, 0, 1, 0, 0);
    tag = "R8";  frame(16, 16, 16, 16, 1, 1, 0, 0);
    tag = "R1";  frame(24, 18, 16, 16, 1, 1, 1, 0);
    tag = "R10"; frame(48, 32, 20, 17, 1, 1, 0, 1);
    tag = "R5";  frame(16, 40, 16, 16, 0, 0, 0, 0);
    tag = "R5";  frame(20, 37, 19, 23, 1, 1, 0, 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule